// File: doc/BRIEF.md
# Storage Row Sequencer with Fast Cueing

This block steps the row address of a sample storage array while a recording or a playback runs. Timing comes from a sample-rate enable: every row spans a fixed number of sample ticks. The block also produces a row-access clock level for the pin. That level stays high through most of a row and drops low for a short window at the end of the row, so outside logic can count rows and tell where a row finishes.

A cue mode lets a controller skip through stored messages. It uses a separate fast enable, which runs 512 times faster than the sample tick. It keeps the same per-row tick count and the same low window. It stops at the end of the first row whose end-of-message bit is set, and it leaves the address on the next row. When the counter reaches the last row of the array, an end-of-memory flag is set and the counter stops there. A start address is loaded in byte units, and the five least significant bits of that address are ignored.

On the first row after a record start, the row runs one low window longer and the pin stays high for that extra time. This gives the sampling front end time to settle before the first row boundary is signalled.

Top module: `row_sequencer`

## Requirements
- R1: After reset, `row_addr` is 0, `rac` is 1, `busy` is 0 and `end_of_mem` is 0.
- R2: While idle, a `load` pulse sets `row_addr` to `load_addr >> 5`, so bits 4:0 are ignored, and clears `end_of_mem`. A result of NUM_ROWS-1 or more sets `row_addr` to NUM_ROWS-1 and sets `end_of_mem`. A `load` while busy has no effect.
- R3: In record or playback, `row_addr` advances by one after every ROW_TICKS `tick` pulses, counted from the start. Ticks received while idle change nothing.
- R4: While busy, `rac` is 0 during the last LOW_TICKS ticks of each row and 1 for the rest of the row. While idle, `rac` is 1.
- R5: The first row after a record start lasts ROW_TICKS+LOW_TICKS ticks. `rac` is 1 for the first ROW_TICKS ticks of that row and 0 for the last LOW_TICKS ticks. Later rows follow R3 and R4.
- R6: In cue mode only `fast_tick` advances the row, with the same tick count per row and the same `rac` window. `tick` is ignored in cue mode, and `fast_tick` is ignored in record and playback.
- R7: In cue mode, if `eom_in` is 1 at the end of a row, the sequencer moves to the next row and goes idle.
- R8: Advancing into row NUM_ROWS-1 sets `end_of_mem` and makes the block idle, so the row does not move again. While `end_of_mem` is 1, start commands are refused.
- R9: `stop` makes the block idle on the next cycle with `rac` at 1 and the row held. The next start begins a full row.
- R10: When idle, start commands have this priority: record, then playback, then cue. Any start wins over a `load` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Sample-rate enable pulse |
| fast_tick | input | 1 | Cue-rate enable pulse |
| start_rec | input | 1 | Start record |
| start_play | input | 1 | Start playback |
| start_cue | input | 1 | Start cueing |
| stop | input | 1 | Stop the running operation |
| load | input | 1 | Load the start address |
| load_addr | input | ADDR_W+5 | Byte-granular start address |
| eom_in | input | 1 | End-of-message bit of the current row |
| row_addr | output | ADDR_W | Current row |
| rac | output | 1 | Row-access clock level |
| busy | output | 1 | An operation is running |
| end_of_mem | output | 1 | Last row reached |

## Verification
The hardest case to reach is a cue run that ends on a row carrying an end-of-message marker. The row must advance exactly once more and then hold, while the sample tick keeps arriving. The stimulus loads a row two below the marked row and starts cueing. It first sends sample ticks to show they are ignored, then sends fast ticks in row-sized bursts, and checks the address and the low window after each burst. Reaching the end-of-memory stop also takes care from the ports: a byte address that lands one row below the last row is loaded, so a single row of playback reaches the limit.

// File: rtl/rowseq_pkg.sv
package rowseq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_REC  = 2'd1,
    SEQ_PLAY = 2'd2,
    SEQ_CUE  = 2'd3
  } seq_mode_e;
endpackage

// File: rtl/rowseq_ctrl.sv
module rowseq_ctrl
  import rowseq_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int LAST_ROW = 1887
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_rec,
  input  logic              start_play,
  input  logic              start_cue,
  input  logic              stop,
  input  logic              load,
  input  logic              row_end,
  input  logic              eom_in,
  input  logic              mem_full,
  input  logic [ADDR_W-1:0] row_q,
  output seq_mode_e         mode_q,
  output logic              first_row_q,
  output logic              busy,
  output logic              load_ok,
  output logic              advance
);
  localparam logic [ADDR_W-1:0] PRE_LAST = ADDR_W'(LAST_ROW - 1);

  seq_mode_e mode_d;
  logic      first_row_d;
  logic      idle;
  logic      may_start;

  assign idle      = (mode_q == SEQ_IDLE);
  assign busy      = ~idle;
  assign may_start = idle & ~mem_full;
  assign load_ok   = idle & load & ~start_rec & ~start_play & ~start_cue;
  assign advance   = row_end & ~stop;

  always_comb begin
    mode_d      = mode_q;
    first_row_d = first_row_q;
    if (idle) begin
      if (may_start) begin
        if (start_rec) begin
          mode_d      = SEQ_REC;
          first_row_d = 1'b1;
        end else if (start_play) begin
          mode_d = SEQ_PLAY;
        end else if (start_cue) begin
          mode_d = SEQ_CUE;
        end
      end
    end else if (stop) begin
      mode_d      = SEQ_IDLE;
      first_row_d = 1'b0;
    end else if (row_end) begin
      first_row_d = 1'b0;
      if ((mode_q == SEQ_CUE && eom_in) || row_q == PRE_LAST) begin
        mode_d = SEQ_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= SEQ_IDLE;
      first_row_q <= 1'b0;
    end else begin
      mode_q      <= mode_d;
      first_row_q <= first_row_d;
    end
  end

  // R7
  cue_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == SEQ_CUE && row_end && eom_in && !stop) |=> (mode_q == SEQ_IDLE));

  // R9
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stop) |=> (mode_q == SEQ_IDLE));

  // R8
  full_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && mem_full) |=> idle);
endmodule

// File: rtl/rowseq_phase.sv
module rowseq_phase #(
  parameter int ROW_TICKS = 2048,
  parameter int LOW_TICKS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic step,
  input  logic stop,
  input  logic first_row,
  output logic row_end,
  output logic rac
);
  localparam int PH_W = $clog2(ROW_TICKS + LOW_TICKS);
  localparam logic [PH_W-1:0] END_NORM  = PH_W'(ROW_TICKS - 1);
  localparam logic [PH_W-1:0] END_FIRST = PH_W'(ROW_TICKS + LOW_TICKS - 1);
  localparam logic [PH_W-1:0] LOW_NORM  = PH_W'(ROW_TICKS - LOW_TICKS);
  localparam logic [PH_W-1:0] LOW_FIRST = PH_W'(ROW_TICKS);

  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] phase_d;
  logic [PH_W-1:0] row_last;
  logic [PH_W-1:0] low_start;

  assign row_last  = first_row ? END_FIRST : END_NORM;
  assign low_start = first_row ? LOW_FIRST : LOW_NORM;
  assign row_end   = busy & step & (phase_q == row_last);
  assign rac       = ~(busy & (phase_q >= low_start));

  always_comb begin
    phase_d = phase_q;
    if (!busy || stop) begin
      phase_d = '0;
    end else if (step) begin
      phase_d = row_end ? '0 : phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  // R5
  phase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= END_FIRST);

  // R4
  idle_rac_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> rac);

  // R4
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !step && !stop) |=> $stable(phase_q) || !busy);
endmodule

// File: rtl/rowseq_addr.sv
module rowseq_addr #(
  parameter int ADDR_W   = 11,
  parameter int LAST_ROW = 1887,
  parameter int ROW_LSB  = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load_ok,
  input  logic [ADDR_W+ROW_LSB-1:0] load_addr,
  input  logic                      advance,
  output logic [ADDR_W-1:0]         row_q,
  output logic                      full_q
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(LAST_ROW);
  localparam logic [ADDR_W-1:0] PRE  = ADDR_W'(LAST_ROW - 1);

  logic [ADDR_W-1:0] load_row;
  logic [ADDR_W-1:0] row_d;
  logic              full_d;

  assign load_row = ADDR_W'(load_addr >> ROW_LSB);

  always_comb begin
    row_d  = row_q;
    full_d = full_q;
    if (load_ok) begin
      if (load_row >= LAST) begin
        row_d  = LAST;
        full_d = 1'b1;
      end else begin
        row_d  = load_row;
        full_d = 1'b0;
      end
    end else if (advance) begin
      row_d  = row_q + 1'b1;
      full_d = (row_q == PRE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      full_q <= 1'b0;
    end else begin
      row_q  <= row_d;
      full_q <= full_d;
    end
  end

  // R8
  row_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_q <= LAST);

  // R8
  full_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> (row_q == LAST));

  // R3
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_ok |=> (row_q == $past(row_q)) || (row_q == $past(row_q) + 1'b1));
endmodule

// File: rtl/row_sequencer.sv
module row_sequencer
  import rowseq_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int NUM_ROWS  = 1888,
  parameter int ROW_TICKS = 2048,
  parameter int LOW_TICKS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              fast_tick,
  input  logic              start_rec,
  input  logic              start_play,
  input  logic              start_cue,
  input  logic              stop,
  input  logic              load,
  input  logic [ADDR_W+4:0] load_addr,
  input  logic              eom_in,
  output logic [ADDR_W-1:0] row_addr,
  output logic              rac,
  output logic              busy,
  output logic              end_of_mem
);
  localparam int LAST_ROW = NUM_ROWS - 1;
  localparam int ROW_LSB  = 5;

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  seq_mode_e  mode;
  logic       first_row;
  logic       step;
  logic       row_end;
  logic       load_ok;
  logic       advance;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  assign step = (mode == SEQ_CUE) ? fast_tick : tick;

  rowseq_ctrl #(.ADDR_W(ADDR_W), .LAST_ROW(LAST_ROW)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n),
    .start_rec(start_rec), .start_play(start_play), .start_cue(start_cue),
    .stop(stop), .load(load), .row_end(row_end), .eom_in(eom_in),
    .mem_full(end_of_mem), .row_q(row_addr),
    .mode_q(mode), .first_row_q(first_row), .busy(busy),
    .load_ok(load_ok), .advance(advance)
  );

  rowseq_phase #(.ROW_TICKS(ROW_TICKS), .LOW_TICKS(LOW_TICKS)) u_phase (
    .clk(clk), .rst_n(rst_sync_n), .busy(busy), .step(step), .stop(stop),
    .first_row(first_row), .row_end(row_end), .rac(rac)
  );

  rowseq_addr #(.ADDR_W(ADDR_W), .LAST_ROW(LAST_ROW), .ROW_LSB(ROW_LSB)) u_addr (
    .clk(clk), .rst_n(rst_sync_n), .load_ok(load_ok), .load_addr(load_addr),
    .advance(advance), .row_q(row_addr), .full_q(end_of_mem)
  );

  // R9
  stop_rac_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && stop) |=> (rac && $stable(row_addr)));

  // R2
  busy_load_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && load && !row_end) |=> $stable(row_addr));
endmodule

// File: tb/row_sequencer_tb.sv
module row_sequencer_tb;
  localparam int ADDR_W    = 11;
  localparam int NUM_ROWS  = 20;
  localparam int ROW_TICKS = 16;
  localparam int LOW_TICKS = 4;

  localparam logic [2:0] OP_TICK = 3'd0;
  localparam logic [2:0] OP_REC  = 3'd1;
  localparam logic [2:0] OP_PLAY = 3'd2;
  localparam logic [2:0] OP_CUE  = 3'd3;
  localparam logic [2:0] OP_STOP = 3'd4;
  localparam logic [2:0] OP_LOAD = 3'd5;
  localparam logic [2:0] OP_FAST = 3'd6;

  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] arg;
    logic [10:0] row;
    logic        rac;
    logic        busy;
    logic        eom;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 39;
  // op, arg, row, rac, busy, end_of_mem, requirement
  localparam vec_t VEC [0:NV-1] = '{
    '{OP_LOAD, 16'h0065, 11'd3,  1'b1, 1'b0, 1'b0, 4'd2},  // R2 low bits dropped
    '{OP_PLAY, 16'd0,    11'd3,  1'b1, 1'b1, 1'b0, 4'd3},
    '{OP_TICK, 16'd11,   11'd3,  1'b1, 1'b1, 1'b0, 4'd4},
    '{OP_TICK, 16'd1,    11'd3,  1'b0, 1'b1, 1'b0, 4'd4},  // R4 low window
    '{OP_LOAD, 16'h0000, 11'd3,  1'b0, 1'b1, 1'b0, 4'd2},  // R2 ignored busy
    '{OP_TICK, 16'd3,    11'd3,  1'b0, 1'b1, 1'b0, 4'd4},
    '{OP_TICK, 16'd1,    11'd4,  1'b1, 1'b1, 1'b0, 4'd3},  // R3 advance
    '{OP_FAST, 16'd16,   11'd4,  1'b1, 1'b1, 1'b0, 4'd6},  // R6 fast ignored
    '{OP_STOP, 16'd0,    11'd4,  1'b1, 1'b0, 1'b0, 4'd9},
    '{OP_TICK, 16'd40,   11'd4,  1'b1, 1'b0, 1'b0, 4'd3},  // R3 idle ticks
    '{OP_REC,  16'd0,    11'd4,  1'b1, 1'b1, 1'b0, 4'd5},
    '{OP_TICK, 16'd15,   11'd4,  1'b1, 1'b1, 1'b0, 4'd5},  // R5 still high
    '{OP_TICK, 16'd1,    11'd4,  1'b0, 1'b1, 1'b0, 4'd5},
    '{OP_TICK, 16'd3,    11'd4,  1'b0, 1'b1, 1'b0, 4'd5},
    '{OP_TICK, 16'd1,    11'd5,  1'b1, 1'b1, 1'b0, 4'd5},
    '{OP_TICK, 16'd12,   11'd5,  1'b0, 1'b1, 1'b0, 4'd4},
    '{OP_TICK, 16'd4,    11'd6,  1'b1, 1'b1, 1'b0, 4'd3},
    '{OP_STOP, 16'd0,    11'd6,  1'b1, 1'b0, 1'b0, 4'd9},
    '{OP_LOAD, 16'h0240, 11'd18, 1'b1, 1'b0, 1'b0, 4'd2},
    '{OP_PLAY, 16'd0,    11'd18, 1'b1, 1'b1, 1'b0, 4'd3},
    '{OP_TICK, 16'd16,   11'd19, 1'b1, 1'b0, 1'b1, 4'd8},  // R8 limit
    '{OP_TICK, 16'd16,   11'd19, 1'b1, 1'b0, 1'b1, 4'd8},
    '{OP_PLAY, 16'd0,    11'd19, 1'b1, 1'b0, 1'b1, 4'd8},  // R8 refused
    '{OP_LOAD, 16'h0FFF, 11'd19, 1'b1, 1'b0, 1'b1, 4'd2},  // R2 clamp
    '{OP_LOAD, 16'h00E0, 11'd7,  1'b1, 1'b0, 1'b0, 4'd8},  // R8 cleared
    '{OP_CUE,  16'd0,    11'd7,  1'b1, 1'b1, 1'b0, 4'd6},
    '{OP_TICK, 16'd16,   11'd7,  1'b1, 1'b1, 1'b0, 4'd6},  // R6 tick ignored
    '{OP_FAST, 16'd12,   11'd7,  1'b0, 1'b1, 1'b0, 4'd6},
    '{OP_FAST, 16'd4,    11'd8,  1'b1, 1'b1, 1'b0, 4'd6},
    '{OP_FAST, 16'd16,   11'd9,  1'b1, 1'b1, 1'b0, 4'd6},
    '{OP_FAST, 16'd16,   11'd10, 1'b1, 1'b0, 1'b0, 4'd7},  // R7 stop after marker
    '{OP_FAST, 16'd16,   11'd10, 1'b1, 1'b0, 1'b0, 4'd7},
    '{OP_PLAY, 16'd0,    11'd10, 1'b1, 1'b1, 1'b0, 4'd3},
    '{OP_TICK, 16'd13,   11'd10, 1'b0, 1'b1, 1'b0, 4'd4},
    '{OP_STOP, 16'd0,    11'd10, 1'b1, 1'b0, 1'b0, 4'd9},  // R9 rac high
    '{OP_PLAY, 16'd0,    11'd10, 1'b1, 1'b1, 1'b0, 4'd9},
    '{OP_TICK, 16'd11,   11'd10, 1'b1, 1'b1, 1'b0, 4'd9},  // R9 full row
    '{OP_TICK, 16'd5,    11'd11, 1'b1, 1'b1, 1'b0, 4'd3},
    '{OP_STOP, 16'd0,    11'd11, 1'b1, 1'b0, 1'b0, 4'd9}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick = 1'b0;
  logic              fast_tick = 1'b0;
  logic              start_rec = 1'b0;
  logic              start_play = 1'b0;
  logic              start_cue = 1'b0;
  logic              stop = 1'b0;
  logic              load = 1'b0;
  logic [ADDR_W+4:0] load_addr = '0;
  logic              eom_in;
  logic [ADDR_W-1:0] row_addr;
  logic              rac;
  logic              busy;
  logic              end_of_mem;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  // row 9 carries the end-of-message marker
  assign eom_in = (row_addr == 11'd9);

  row_sequencer #(
    .ADDR_W(ADDR_W), .NUM_ROWS(NUM_ROWS),
    .ROW_TICKS(ROW_TICKS), .LOW_TICKS(LOW_TICKS)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fast_tick(fast_tick),
    .start_rec(start_rec), .start_play(start_play), .start_cue(start_cue),
    .stop(stop), .load(load), .load_addr(load_addr), .eom_in(eom_in),
    .row_addr(row_addr), .rac(rac), .busy(busy), .end_of_mem(end_of_mem)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input int r, input int ra,
                           input int b, input int e);
    check({tag, " row"}, int'(row_addr), r);
    check({tag, " rac"}, int'(rac), ra);
    check({tag, " busy"}, int'(busy), b);
    check({tag, " end_of_mem"}, int'(end_of_mem), e);
  endtask

  task automatic apply(input logic [2:0] op, input logic [15:0] arg);
    case (op)
      OP_TICK: for (int k = 0; k < int'(arg); k++) begin
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
      end
      OP_FAST: for (int k = 0; k < int'(arg); k++) begin
        @(negedge clk) fast_tick = 1'b1;
        @(negedge clk) fast_tick = 1'b0;
      end
      OP_REC:  begin @(negedge clk) start_rec = 1'b1;  @(negedge clk) start_rec = 1'b0;  end
      OP_PLAY: begin @(negedge clk) start_play = 1'b1; @(negedge clk) start_play = 1'b0; end
      OP_CUE:  begin @(negedge clk) start_cue = 1'b1;  @(negedge clk) start_cue = 1'b0;  end
      OP_STOP: begin @(negedge clk) stop = 1'b1;       @(negedge clk) stop = 1'b0;       end
      OP_LOAD: begin
        @(negedge clk) begin load = 1'b1; load_addr = arg; end
        @(negedge clk) load = 1'b0;
      end
      default: @(negedge clk);
    endcase
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1 reset", 0, 1, 0, 0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].op, VEC[i].arg);
      check_all($sformatf("R%0d vec%0d", VEC[i].req, i),
                int'(VEC[i].row), int'(VEC[i].rac), int'(VEC[i].busy), int'(VEC[i].eom));
    end

    // R1: reset in the middle of a playback
    apply(OP_PLAY, 16'd0);
    apply(OP_TICK, 16'd14);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check_all("R1 mid-run reset", 0, 1, 0, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10: record wins over playback and cue in the same cycle
    @(negedge clk) begin start_rec = 1'b1; start_play = 1'b1; start_cue = 1'b1; end
    @(negedge clk) begin start_rec = 1'b0; start_play = 1'b0; start_cue = 1'b0; end
    apply(OP_TICK, 16'd16);
    check_all("R10 rec priority", 0, 0, 1, 0);
    apply(OP_STOP, 16'd0);

    // R10: playback wins over cue; fast ticks must not move it
    @(negedge clk) begin start_play = 1'b1; start_cue = 1'b1; end
    @(negedge clk) begin start_play = 1'b0; start_cue = 1'b0; end
    apply(OP_FAST, 16'd16);
    check_all("R10 play over cue", 0, 1, 1, 0);
    apply(OP_STOP, 16'd0);

    // R10: a start wins over a load in the same cycle
    @(negedge clk) begin start_play = 1'b1; load = 1'b1; load_addr = 16'h00A0; end
    @(negedge clk) begin start_play = 1'b0; load = 1'b0; end
    check_all("R10 start over load", 0, 1, 1, 0);
    apply(OP_STOP, 16'd0);

    done = 1'b1;
    finish_run();
  end
endmodule